// File: doc/BRIEF.md
# Circular Double-Buffer Sample Writer

This block accepts a stream of samples from a serial receiver. Each sample arrives with a valid strobe. The block stores the samples in a circular memory of 256 entries. The write address moves forward by one for each valid sample. After the last entry it returns to entry 0 without any help from software, so capture never stops.

The memory is split into a lower half (entries 0 to 127) and an upper half (entries 128 to 255). When the last entry of a half has been written, the block raises a one-cycle interrupt pulse and sets a sticky ready flag for that half. Software reads that half through the read port while the writer fills the other half. Software then pulses a release input for the half it has finished.

If the writer wraps into a half that is still marked ready, the consumer has fallen behind. In that case the block sets a sticky overrun flag and keeps overwriting.

Top module: `ppb_sampler`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears `lo_ready`, `hi_ready`, `overrun`, `half_irq` and `full_irq`, and returns the write address to 0. The first valid sample after reset is stored at entry 0.
- R2: Each cycle with `smp_valid` high writes `smp_data` to the current write address, then advances the address by one. Cycles with `smp_valid` low write nothing and leave the address unchanged.
- R3: After the sample at entry 255 is written, the next valid sample goes to entry 0.
- R4: `half_irq` is high for exactly one cycle. That cycle is the one right after the clock edge that writes entry 127.
- R5: `full_irq` is high for exactly one cycle. That cycle is the one right after the clock edge that writes entry 255.
- R6: `lo_ready` rises together with `half_irq` and stays high until a cycle with `lo_release` high. `hi_ready` behaves the same way with `full_irq` and `hi_release`.
- R7: Writing never pauses because a ready flag is set. Back-to-back valid samples are all stored while software holds a half.
- R8: A valid write to entry 0 while `lo_ready` is set, or to entry 128 while `hi_ready` is set, sets `overrun` (unless the matching release is high in that same cycle). The sample is still stored. `overrun` stays set until a cycle with `ovr_clear` high.
- R9: `rd_data` returns the entry at `rd_addr` one clock after `rd_addr` is presented.
- R10: When a set condition and a clear input for the same flag occur in the same cycle, the set wins. This applies to both ready flags and to `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | DATA_W | Sample value |
| rd_addr | input | log2(DEPTH) | Consumer read address |
| rd_data | output | DATA_W | Read data, one-cycle latency |
| lo_release | input | 1 | Pulse: consumer is done with the lower half |
| hi_release | input | 1 | Pulse: consumer is done with the upper half |
| ovr_clear | input | 1 | Pulse: clears the overrun flag |
| half_irq | output | 1 | One-cycle pulse when the lower half is complete |
| full_irq | output | 1 | One-cycle pulse when the upper half is complete |
| lo_ready | output | 1 | Sticky: lower half is waiting for the consumer |
| hi_ready | output | 1 | Sticky: upper half is waiting for the consumer |
| overrun | output | 1 | Sticky: the writer entered an unreleased half |

## Verification
Samples are sent in bursts of different lengths, both back to back and with idle gaps of one to three cycles. During the gaps the data lines carry junk, which must not be written. This separates correct address advance from writes on invalid cycles, and it shows that the interrupt pulses are one cycle wide whatever the spacing. The sequence includes three kinds of half entry: after a release (no overrun), without a release (overrun), and a long run of 300 samples that wraps. Directed cases cover a release and a completion in the same cycle, an overrun and an `ovr_clear` in the same cycle, and a reset in the middle of a run. A readback of the whole memory then compares every entry against an independent model.

// File: rtl/ppb_pkg.sv
package ppb_pkg;

  // Events that belong to a single accepted write.
  typedef struct packed {
    logic half_done;  // entry HALF-1 written
    logic full_done;  // entry DEPTH-1 written
    logic enter_lo;   // entry 0 written
    logic enter_hi;   // entry HALF written
  } wr_evt_t;

  // Pointer advance, with the wrap written out so a non-power-of-two depth also works.
  function automatic int unsigned wrap_inc(int unsigned p, int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Sticky flag update: a new set takes priority over a clear in the same cycle.
  function automatic logic sticky_next(logic cur, logic set_c, logic clr_c);
    return set_c | (cur & ~clr_c);
  endfunction

endpackage

// File: rtl/ppb_wr_ptr.sv
module ppb_wr_ptr
  import ppb_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = DEPTH / 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  output logic [AW-1:0] ptr,
  output wr_evt_t       evt
);

  localparam logic [AW-1:0] LAST_A   = AW'(DEPTH - 1);
  localparam logic [AW-1:0] HALFL_A  = AW'(HALF - 1);
  localparam logic [AW-1:0] HALF_A   = AW'(HALF);

  always_ff @(posedge clk) begin
    if (rst)        ptr <= '0;
    else if (valid) ptr <= AW'(wrap_inc(32'(ptr), DEPTH));
  end

  always_comb begin
    evt.half_done = valid && (ptr == HALFL_A);
    evt.full_done = valid && (ptr == LAST_A);
    evt.enter_lo  = valid && (ptr == '0);
    evt.enter_hi  = valid && (ptr == HALF_A);
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !valid |=> $stable(ptr)); // R2
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (valid && ptr == LAST_A) |=> (ptr == '0)); // R3

endmodule

// File: rtl/ppb_store.sv
module ppb_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ppb_owner.sv
module ppb_owner
  import ppb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  wr_evt_t evt,
  input  logic    lo_release,
  input  logic    hi_release,
  input  logic    ovr_clear,
  output logic    half_irq,
  output logic    full_irq,
  output logic    lo_ready,
  output logic    hi_ready,
  output logic    overrun
);

  // The writer enters a half that the consumer still holds.
  logic ovr_hit;
  assign ovr_hit = (evt.enter_lo && lo_ready && !lo_release) ||
                   (evt.enter_hi && hi_ready && !hi_release);

  always_ff @(posedge clk) begin
    if (rst) begin
      half_irq <= 1'b0;
      full_irq <= 1'b0;
      lo_ready <= 1'b0;
      hi_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      half_irq <= evt.half_done;
      full_irq <= evt.full_done;
      lo_ready <= sticky_next(lo_ready, evt.half_done, lo_release);
      hi_ready <= sticky_next(hi_ready, evt.full_done, hi_release);
      overrun  <= sticky_next(overrun, ovr_hit, ovr_clear);
    end
  end

  AST_HALF_ONE: assert property (@(posedge clk) disable iff (rst)
    half_irq |=> !half_irq); // R4
  AST_FULL_ONE: assert property (@(posedge clk) disable iff (rst)
    full_irq |=> !full_irq); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (lo_ready && !lo_release) |=> lo_ready); // R6
  AST_HI_HOLD: assert property (@(posedge clk) disable iff (rst)
    (hi_ready && !hi_release) |=> hi_ready); // R6
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (overrun && !ovr_clear) |=> overrun); // R8
  AST_LO_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    evt.half_done |=> (lo_ready && half_irq)); // R10
  AST_HI_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    evt.full_done |=> (hi_ready && full_irq)); // R10

endmodule

// File: rtl/ppb_sampler.sv
module ppb_sampler
  import ppb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              lo_release,
  input  logic              hi_release,
  input  logic              ovr_clear,
  output logic              half_irq,
  output logic              full_irq,
  output logic              lo_ready,
  output logic              hi_ready,
  output logic              overrun
);

  logic [AW-1:0] wr_ptr;
  wr_evt_t       wr_evt;

  ppb_wr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .valid (smp_valid),
    .ptr   (wr_ptr),
    .evt   (wr_evt)
  );

  ppb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .we    (smp_valid),
    .waddr (wr_ptr),
    .wdata (smp_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  ppb_owner u_owner (
    .clk        (clk),
    .rst        (rst),
    .evt        (wr_evt),
    .lo_release (lo_release),
    .hi_release (hi_release),
    .ovr_clear  (ovr_clear),
    .half_irq   (half_irq),
    .full_irq   (full_irq),
    .lo_ready   (lo_ready),
    .hi_ready   (hi_ready),
    .overrun    (overrun)
  );

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!lo_ready && !hi_ready && !overrun && !half_irq && !full_irq)); // R1
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(half_irq && full_irq)); // R5

endmodule

// File: tb/test_ppb_sampler.sv
module test_ppb_sampler;

  localparam int DW   = 16;
  localparam int DEP  = 256;
  localparam int HALF = DEP / 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          smp_valid = 1'b0;
  logic [DW-1:0] smp_data = '0;
  logic [7:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          lo_release = 1'b0, hi_release = 1'b0, ovr_clear = 1'b0;
  logic          half_irq, full_irq, lo_ready, hi_ready, overrun;

  always #2 clk = ~clk;

  ppb_sampler #(.DATA_W(DW), .DEPTH(DEP)) i_ppb_sampler (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_data(smp_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .lo_release(lo_release),
    .hi_release(hi_release), .ovr_clear(ovr_clear), .half_irq(half_irq),
    .full_irq(full_irq), .lo_ready(lo_ready), .hi_ready(hi_ready),
    .overrun(overrun)
  );

  int vectors = 0, miscompares = 0;
  int half_seen = 0, full_seen = 0;
  int seq = 0;
  int mwp = 0;
  bit mlo = 0, mhi = 0, movr = 0;
  logic [DW-1:0] mmem [DEP];
  logic [DW-1:0] lastd;

  // Pulse counter: one count per cycle the pulse is high.
  always @(negedge clk) begin
    if (half_irq) half_seen++;
    if (full_irq) full_seen++;
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock cycle of stimulus, with the bench model updated from the requirements.
  task automatic tick(bit v, logic [DW-1:0] d, bit rl, bit rh, bit co);
    bit s_ovr, s_lo, s_hi;
    smp_valid = v; smp_data = d; lo_release = rl; hi_release = rh; ovr_clear = co;
    @(negedge clk);
    s_ovr = v && ((mwp == 0 && mlo && !rl) || (mwp == HALF && mhi && !rh));
    s_lo  = v && (mwp == HALF - 1);
    s_hi  = v && (mwp == DEP - 1);
    movr  = s_ovr || (movr && !co);
    mlo   = s_lo || (mlo && !rl);
    mhi   = s_hi || (mhi && !rh);
    if (v) begin
      mmem[mwp] = d;
      lastd = d;
      mwp = (mwp + 1) % DEP;
    end
    smp_valid = 1'b0; smp_data = 16'hBAD0; lo_release = 1'b0; hi_release = 1'b0; ovr_clear = 1'b0;
  endtask

  task automatic read_at(int a, output logic [DW-1:0] q);
    rd_addr = 8'(a);
    @(negedge clk);
    q = rd_data;
  endtask

  task automatic push(int n, int gap);
    for (int k = 0; k < n; k++) begin
      seq++;
      tick(1'b1, 16'(seq * 40503 + 7), 1'b0, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) tick(1'b0, 16'hF00D, 1'b0, 1'b0, 1'b0);
    end
  endtask

  // {n[31:22], gap[21:18], rel_lo, rel_hi, clr_ovr, halves[14:13], fulls[12:11], lo, hi, ovr, next_wp[7:0]}
  localparam logic [31:0] VEC [8] = '{
    {10'd100, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'd100},
    {10'd28,  4'd1, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1, 1'b0, 1'b0, 8'd128},
    {10'd128, 4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b1, 1'b1, 1'b0, 8'd0},
    {10'd64,  4'd2, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 8'd64},
    {10'd64,  4'd0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b1, 1'b1, 1'b0, 8'd128},
    {10'd1,   4'd0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 8'd129},
    {10'd127, 4'd0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 8'd0},
    {10'd300, 4'd3, 1'b0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b1, 1'b1, 1'b1, 8'd44}
  };

  bit done = 0;

  initial begin
    logic [DW-1:0] q;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: state right after reset
    check("R1 lo_ready", int'(lo_ready), 0);
    check("R1 hi_ready", int'(hi_ready), 0);
    check("R1 overrun", int'(overrun), 0);
    check("R1 irq", int'(half_irq | full_irq), 0);

    for (int i = 0; i < 8; i++) begin
      logic [31:0] v;
      int h0, f0;
      v = VEC[i];
      h0 = half_seen; f0 = full_seen;
      if (v[17] || v[16] || v[15]) tick(1'b0, 16'h0, v[17], v[16], v[15]);
      push(int'(v[31:22]), int'(v[21:18]));
      tick(1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
      check("R4 half_irq cycles", half_seen - h0, int'(v[14:13]));
      check("R5 full_irq cycles", full_seen - f0, int'(v[12:11]));
      check("R6 lo_ready", int'(lo_ready), int'(v[10]));
      check("R6 hi_ready", int'(hi_ready), int'(v[9]));
      check("R8 overrun", int'(overrun), int'(v[8]));
      // R2/R3: the last sample sits just below the expected next address
      read_at((int'(v[7:0]) + DEP - 1) % DEP, q);
      check("R3 last sample", int'(q), int'(lastd));
    end

    // R8: clear overrun, then the flag is low
    tick(1'b0, 16'h0, 1'b0, 1'b0, 1'b1);
    check("R8 overrun cleared", int'(overrun), 0);
    // R10: write of entry 127 with lo_release in the same cycle keeps lo_ready
    push(83, 0);
    tick(1'b1, 16'h5A5A, 1'b1, 1'b0, 1'b0);
    tick(1'b0, 16'h0, 1'b0, 1'b0, 1'b0);
    check("R10 lo set over release", int'(lo_ready), 1);
    // R10: overrun at entry 128 with ovr_clear in the same cycle
    tick(1'b1, 16'hA5C3, 1'b0, 1'b0, 1'b1);
    check("R10 ovr set over clear", int'(overrun), 1);
    read_at(HALF, q);
    check("R8 overwrite stored", int'(q), 16'hA5C3);

    // R9, R2, R7: full readback against the model
    for (int a = 0; a < DEP; a++) begin
      read_at(a, q);
      check("R9 readback", int'(q), int'(mmem[a]));
    end

    // R1: reset in the middle of a run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mwp = 0; mlo = 0; mhi = 0; movr = 0;
    check("R1 mid-run flags", int'({lo_ready, hi_ready, overrun, half_irq, full_irq}), 0);
    tick(1'b1, 16'h1234, 1'b0, 1'b0, 1'b0);
    read_at(0, q);
    check("R1 first sample at 0", int'(q), 16'h1234);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule